// File: doc/BRIEF.md
# Speculative Read/Write-Set Cache Tracker

This block holds the tag-side state of a private first-level cache that runs code in speculative chunks. Next to the usual valid and dirty flags, each line keeps two marks: one saying the line was read inside the current chunk and one saying it was written inside it. Loads and stores issued while the core is speculating set these marks. A speculative store that would overwrite a dirty line that is not yet in the write set is held back until that line has been written back. This keeps a clean copy from before the chunk for recovery.

Coherence probes from other agents are looked up against the marks, and the block reports whether the probe breaks the chunk's atomicity and how. A commit pulse clears every mark in one cycle. An abort pulse drops every line in the write set and clears all marks in the same cycle. When the replacement logic proposes a victim that carries a mark, the block raises a force-commit request so the line is not evicted while still being tracked. Lines are addressed by a direct line index. Tag compare, the data array and the replacement choice all live outside this block.

Top module: `spt_tracker`

## Requirements
- R1: After reset every line is invalid, clean and unmarked. `wb_req` and `force_commit` are low, and a probe to any line reports `snoop_hit`=0 and `snoop_kind`=2'b00.
- R2: A load accepted (`acc_valid` and `acc_ready` high, `acc_store`=0) while `spec_active` is high makes the line valid and marks it read-speculative. A load accepted while `spec_active` is low makes the line valid and leaves it unmarked.
- R3: A speculative store to a line that is valid, dirty and not write-marked is not accepted at first: `acc_ready` is 0 and, from the next cycle on, `wb_req`=1 with `wb_idx` equal to the line. In the cycle after `wb_done` is seen, `acc_ready` rises and the store merges; the line ends dirty and write-marked.
- R4: A store to a line that is clean, invalid or already write-marked, and any store made outside speculation, is accepted in the same cycle with no write-back. It leaves the line valid and dirty, and write-marked if `spec_active` is high.
- R5: `snoop_kind` encodes 2'b10 for any probe to a write-marked line, 2'b01 for a probe with `snoop_excl`=1 to a line that is only read-marked, and 2'b00 otherwise, including a shared probe (`snoop_excl`=0) to a read-only-marked line. `snoop_hit` reports the line's valid flag.
- R6: A `commit` pulse clears every mark. Lines stay valid and keep their dirty flag.
- R7: An `abort` pulse invalidates every write-marked line and clears every mark. Lines that were only read-marked stay valid. When both pulses are high, abort wins.
- R8: `force_commit` is high in the same cycle that `victim_valid` names a line carrying either mark, and low otherwise.
- R9: While `commit` or `abort` is high, `acc_ready` is 0. A held access is accepted afterwards against the state after the flash operation.
- R10: A probe in the same cycle as a commit or abort pulse is classified against the marks as they stood before that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_active | input | 1 | Core is executing a speculative chunk |
| commit | input | 1 | Flash-clear all marks |
| abort | input | 1 | Flash-drop write set and clear all marks |
| acc_valid | input | 1 | Load/store access request, held until accepted |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_idx | input | IW | Line index of the access |
| acc_ready | output | 1 | Access accepted this cycle |
| wb_req | output | 1 | Pre-speculation write-back in progress |
| wb_idx | output | IW | Line being written back |
| wb_done | input | 1 | Write-back finished |
| snoop_valid | input | 1 | Coherence probe present |
| snoop_excl | input | 1 | Probe is write-type |
| snoop_idx | input | IW | Line index of the probe |
| snoop_hit | output | 1 | Probed line is valid |
| snoop_kind | output | 2 | Violation class (R5 encoding) |
| victim_valid | input | 1 | Replacement proposes a victim |
| victim_idx | input | IW | Victim line index |
| force_commit | output | 1 | Victim carries a speculative mark |

## Verification
Two functions can land in the same cycle: a flash operation and a line update, either an access or a probe lookup. The bench raises `commit` while a load is waiting on `acc_valid` and checks that the load is held and then marks the line as part of the new chunk. It also probes a write-marked line in the very cycle of a commit, where the pre-flash answer 2'b10 is expected, and then again one cycle later, where 2'b00 is expected. Random sequences mix these with write-back stalls, and every response is compared against a line model kept in the bench.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    VK_NONE      = 2'b00,
    VK_READ_SET  = 2'b01,
    VK_WRITE_SET = 2'b10
  } viol_kind_e;

  // Violation class of a probe against one line's marks
  function automatic viol_kind_e classify(input logic valid, input logic rd_mark,
                                          input logic wr_mark, input logic excl);
    viol_kind_e k;
    k = VK_NONE;
    if (valid && wr_mark)               k = VK_WRITE_SET;
    else if (valid && rd_mark && excl)  k = VK_READ_SET;
    return k;
  endfunction

  // A store needs a pre-chunk copy written back first
  function automatic logic needs_pre_wb(input logic spec, input logic is_store,
                                        input logic valid, input logic dirty,
                                        input logic wr_mark);
    return spec && is_store && valid && dirty && !wr_mark;
  endfunction
endpackage

// File: rtl/spt_line_array.sv
module spt_line_array #(
  parameter int NUM_LINES = 8,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flash_commit,
  input  logic                 flash_abort,
  input  logic                 upd_en,
  input  logic [IW-1:0]        upd_idx,
  input  logic                 upd_store,
  input  logic                 upd_spec,
  input  logic                 clean_en,
  input  logic [IW-1:0]        clean_idx,
  output logic [NUM_LINES-1:0] valid_o,
  output logic [NUM_LINES-1:0] dirty_o,
  output logic [NUM_LINES-1:0] rd_mark_o,
  output logic [NUM_LINES-1:0] wr_mark_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit_upd, hit_clean;
    assign hit_upd   = upd_en && (upd_idx == IW'(i));
    assign hit_clean = clean_en && (clean_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[i]   <= 1'b0;
        dirty_o[i]   <= 1'b0;
        rd_mark_o[i] <= 1'b0;
        wr_mark_o[i] <= 1'b0;
      end else if (flash_abort) begin
        if (wr_mark_o[i]) begin
          valid_o[i] <= 1'b0;
          dirty_o[i] <= 1'b0;
        end
        rd_mark_o[i] <= 1'b0;
        wr_mark_o[i] <= 1'b0;
      end else if (flash_commit) begin
        rd_mark_o[i] <= 1'b0;
        wr_mark_o[i] <= 1'b0;
      end else begin
        if (hit_clean) dirty_o[i] <= 1'b0;
        if (hit_upd) begin
          valid_o[i] <= 1'b1;
          if (upd_store) begin
            dirty_o[i] <= 1'b1;
            if (upd_spec) wr_mark_o[i] <= 1'b1;
          end else if (upd_spec) begin
            rd_mark_o[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spt_wb_seq.sv
module spt_wb_seq #(
  parameter int NUM_LINES = 8,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  input  logic          done,
  output logic          busy,
  output logic [IW-1:0] line_idx,
  output logic          finish
);
  typedef enum logic {WB_IDLE, WB_WAIT} wb_state_e;
  wb_state_e state;

  assign busy   = (state == WB_WAIT);
  assign finish = busy && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WB_IDLE;
      line_idx <= '0;
    end else begin
      case (state)
        WB_IDLE: if (start) begin
          state    <= WB_WAIT;
          line_idx <= start_idx;
        end
        WB_WAIT: if (done) state <= WB_IDLE;
        default: state <= WB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spt_probe.sv
module spt_probe #(
  parameter int NUM_LINES = 8,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] valid_i,
  input  logic [NUM_LINES-1:0] rd_mark_i,
  input  logic [NUM_LINES-1:0] wr_mark_i,
  input  logic                 snoop_valid,
  input  logic                 snoop_excl,
  input  logic [IW-1:0]        snoop_idx,
  input  logic                 victim_valid,
  input  logic [IW-1:0]        victim_idx,
  output logic                 snoop_hit,
  output logic [1:0]           snoop_kind,
  output logic                 force_commit
);
  import spt_pkg::*;
  viol_kind_e kind;

  always_comb begin
    kind = classify(valid_i[snoop_idx], rd_mark_i[snoop_idx],
                    wr_mark_i[snoop_idx], snoop_excl);
    snoop_hit  = snoop_valid && valid_i[snoop_idx];
    snoop_kind = snoop_valid ? kind : VK_NONE;
    force_commit = victim_valid && (rd_mark_i[victim_idx] || wr_mark_i[victim_idx]);
  end
endmodule

// File: rtl/spt_tracker.sv
module spt_tracker #(
  parameter int NUM_LINES = 8,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_active,
  input  logic          commit,
  input  logic          abort,
  input  logic          acc_valid,
  input  logic          acc_store,
  input  logic [IW-1:0] acc_idx,
  output logic          acc_ready,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  input  logic          wb_done,
  input  logic          snoop_valid,
  input  logic          snoop_excl,
  input  logic [IW-1:0] snoop_idx,
  output logic          snoop_hit,
  output logic [1:0]    snoop_kind,
  input  logic          victim_valid,
  input  logic [IW-1:0] victim_idx,
  output logic          force_commit
);
  import spt_pkg::*;

  logic [NUM_LINES-1:0] line_valid, line_dirty, line_rd, line_wr;
  logic flash_busy, wb_busy, wb_finish, need_wb, wb_start;

  assign flash_busy = commit || abort;
  assign need_wb    = acc_valid && needs_pre_wb(spec_active, acc_store, line_valid[acc_idx],
                                                line_dirty[acc_idx], line_wr[acc_idx]);
  assign wb_start   = need_wb && !wb_busy && !flash_busy;
  assign acc_ready  = acc_valid && !wb_busy && !flash_busy && !need_wb;
  assign wb_req     = wb_busy;

  spt_line_array #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .flash_commit(commit), .flash_abort(abort),
    .upd_en(acc_ready), .upd_idx(acc_idx), .upd_store(acc_store), .upd_spec(spec_active),
    .clean_en(wb_finish), .clean_idx(wb_idx),
    .valid_o(line_valid), .dirty_o(line_dirty), .rd_mark_o(line_rd), .wr_mark_o(line_wr)
  );

  spt_wb_seq #(.NUM_LINES(NUM_LINES)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .start(wb_start), .start_idx(acc_idx), .done(wb_done),
    .busy(wb_busy), .line_idx(wb_idx), .finish(wb_finish)
  );

  spt_probe #(.NUM_LINES(NUM_LINES)) u_probe (
    .valid_i(line_valid), .rd_mark_i(line_rd), .wr_mark_i(line_wr),
    .snoop_valid(snoop_valid), .snoop_excl(snoop_excl), .snoop_idx(snoop_idx),
    .victim_valid(victim_valid), .victim_idx(victim_idx),
    .snoop_hit(snoop_hit), .snoop_kind(snoop_kind), .force_commit(force_commit)
  );
endmodule

// File: rtl/spt_tracker_checks.sv
module spt_tracker_checks #(
  parameter int NUM_LINES = 8,
  localparam int IW = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 spec_active,
  input logic                 commit,
  input logic                 abort,
  input logic                 acc_valid,
  input logic                 acc_store,
  input logic [IW-1:0]        acc_idx,
  input logic                 acc_ready,
  input logic                 wb_req,
  input logic [IW-1:0]        wb_idx,
  input logic                 wb_done,
  input logic                 snoop_valid,
  input logic [1:0]           snoop_kind,
  input logic                 snoop_hit,
  input logic                 victim_valid,
  input logic                 force_commit,
  input logic [NUM_LINES-1:0] line_valid,
  input logic [NUM_LINES-1:0] line_rd,
  input logic [NUM_LINES-1:0] line_wr
);
  AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready && !acc_store && spec_active |=> line_rd[$past(acc_idx)]); // R2
  AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !acc_ready); // R3
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_done |=> wb_req && $stable(wb_idx)); // R3
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kind != 2'b00 |-> snoop_valid && snoop_hit && snoop_kind != 2'b11); // R5
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !abort |=> line_rd == '0 && line_wr == '0); // R6
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> line_wr == '0 && line_rd == '0 && (line_valid & $past(line_wr)) == '0); // R7
  AST_FORCE_NEEDS_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    force_commit |-> victim_valid); // R8
  AST_FLASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> !acc_ready); // R9
endmodule

bind spt_tracker spt_tracker_checks #(.NUM_LINES(NUM_LINES)) u_checks (
  .clk(clk), .rst_n(rst_n), .spec_active(spec_active), .commit(commit), .abort(abort),
  .acc_valid(acc_valid), .acc_store(acc_store), .acc_idx(acc_idx), .acc_ready(acc_ready),
  .wb_req(wb_req), .wb_idx(wb_idx), .wb_done(wb_done), .snoop_valid(snoop_valid),
  .snoop_kind(snoop_kind), .snoop_hit(snoop_hit), .victim_valid(victim_valid),
  .force_commit(force_commit), .line_valid(line_valid), .line_rd(line_rd), .line_wr(line_wr)
);

// File: tb/test_spt_tracker.sv
module test_spt_tracker;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic spec_active = 0, commit = 0, abort = 0;
  logic acc_valid = 0, acc_store = 0, wb_done = 0;
  logic [IW-1:0] acc_idx = '0, snoop_idx = '0, victim_idx = '0;
  logic snoop_valid = 0, snoop_excl = 0, victim_valid = 0;
  logic acc_ready, wb_req, snoop_hit, force_commit;
  logic [IW-1:0] wb_idx;
  logic [1:0] snoop_kind;

  int errors = 0, checks = 0;
  bit mv[N], md[N], mr[N], mw[N];

  always #5 clk = ~clk;

  spt_tracker #(.NUM_LINES(N)) i_spt_tracker (
    .clk(clk), .rst_n(rst_n), .spec_active(spec_active), .commit(commit), .abort(abort),
    .acc_valid(acc_valid), .acc_store(acc_store), .acc_idx(acc_idx), .acc_ready(acc_ready),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_done(wb_done),
    .snoop_valid(snoop_valid), .snoop_excl(snoop_excl), .snoop_idx(snoop_idx),
    .snoop_hit(snoop_hit), .snoop_kind(snoop_kind),
    .victim_valid(victim_valid), .victim_idx(victim_idx), .force_commit(force_commit)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_kind(input int i, input bit excl);
    if (!mv[i]) return 0;
    if (mw[i]) return 2;
    return (mr[i] && excl) ? 1 : 0;
  endfunction

  task automatic probe(input int i, input bit excl, input string req);
    @(negedge clk);
    snoop_valid = 1; snoop_excl = excl; snoop_idx = IW'(i);
    #1;
    chk(snoop_hit == mv[i], req, "snoop_hit", int'(snoop_hit), int'(mv[i]));
    chk(int'(snoop_kind) == exp_kind(i, excl), req, "snoop_kind", int'(snoop_kind), exp_kind(i, excl));
    snoop_valid = 0;
  endtask

  task automatic victim(input int i);
    @(negedge clk);
    victim_valid = 1; victim_idx = IW'(i);
    #1;
    chk(force_commit == (mr[i] | mw[i]), "R8", "force_commit", int'(force_commit), int'(mr[i] | mw[i]));
    victim_valid = 0;
  endtask

  task automatic access(input int i, input bit st);
    bit want_wb;
    want_wb = st && spec_active && mv[i] && md[i] && !mw[i];
    @(negedge clk);
    acc_valid = 1; acc_store = st; acc_idx = IW'(i);
    #1;
    if (want_wb) begin
      chk(acc_ready == 0, "R3", "acc_ready before write-back", int'(acc_ready), 0);
      @(negedge clk); #1;
      chk(wb_req == 1, "R3", "wb_req", int'(wb_req), 1);
      chk(int'(wb_idx) == i, "R3", "wb_idx", int'(wb_idx), i);
      chk(acc_ready == 0, "R3", "acc_ready during write-back", int'(acc_ready), 0);
      wb_done = 1;
      @(negedge clk); wb_done = 0; #1;
      chk(wb_req == 0, "R3", "wb_req after done", int'(wb_req), 0);
      chk(acc_ready == 1, "R3", "acc_ready after write-back", int'(acc_ready), 1);
    end else begin
      chk(acc_ready == 1, st ? "R4" : "R2", "acc_ready", int'(acc_ready), 1);
      chk(wb_req == 0, "R4", "wb_req", int'(wb_req), 0);
    end
    @(posedge clk); #1;
    acc_valid = 0;
    mv[i] = 1;
    if (st) begin md[i] = 1; if (spec_active) mw[i] = 1; end
    else if (spec_active) mr[i] = 1;
  endtask

  task automatic model_flash(input bit c, input bit a);
    for (int i = 0; i < N; i++) begin
      if (a && mw[i]) begin mv[i] = 0; md[i] = 0; end
      if (a || c) begin mr[i] = 0; mw[i] = 0; end
    end
  endtask

  task automatic flash(input bit c, input bit a);
    @(negedge clk);
    commit = c; abort = a;
    @(posedge clk); #1;
    commit = 0; abort = 0;
    model_flash(c, a);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    chk(wb_req == 0, "R1", "wb_req", int'(wb_req), 0);
    chk(force_commit == 0, "R1", "force_commit", int'(force_commit), 0);
    for (int i = 0; i < N; i++) probe(i, 1, "R1");

    // R2 / R5: non-speculative load unmarked, speculative load marked
    access(0, 0);
    probe(0, 1, "R2");
    spec_active = 1;
    access(1, 0);
    probe(1, 1, "R2");
    probe(1, 0, "R5");
    // R4 clean store, R3 dirty store
    spec_active = 0;
    access(2, 1);
    spec_active = 1;
    access(2, 1);
    probe(2, 0, "R5");
    access(2, 1);
    victim(2); victim(1); victim(0);
    // R10 probe same cycle as commit sees old marks
    @(negedge clk);
    commit = 1; snoop_valid = 1; snoop_excl = 0; snoop_idx = 3'd2;
    #1;
    chk(snoop_kind == 2'b10, "R10", "kind during commit", int'(snoop_kind), 2);
    @(posedge clk); #1; commit = 0; snoop_valid = 0; model_flash(1, 0);
    probe(2, 0, "R6");
    probe(1, 1, "R6");
    // R6 dirty kept: speculative store again needs write-back
    access(2, 1);
    // R9 load held during commit
    @(negedge clk);
    acc_valid = 1; acc_store = 0; acc_idx = 3'd5; commit = 1;
    #1;
    chk(acc_ready == 0, "R9", "acc_ready during commit", int'(acc_ready), 0);
    @(posedge clk); #1; commit = 0; model_flash(1, 0);
    @(negedge clk); #1;
    chk(acc_ready == 1, "R9", "acc_ready after commit", int'(acc_ready), 1);
    @(posedge clk); #1; acc_valid = 0; mv[5] = 1; mr[5] = 1;
    probe(5, 1, "R9");
    // R7 abort with commit: write set dropped, read set kept
    access(6, 1);
    access(4, 0);
    flash(1, 1);
    probe(6, 0, "R7");
    probe(4, 0, "R7");
    probe(5, 1, "R7");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, i;
      op = $urandom_range(0, 11);
      i  = $urandom_range(0, N - 1);
      case (op)
        0, 1, 2: access(i, 0);
        3, 4, 5: access(i, 1);
        6, 7:    probe(i, $urandom_range(0, 1), "R5");
        8:       victim(i);
        9:       flash(1, 0);
        10:      flash($urandom_range(0, 1), 1);
        default: begin @(negedge clk); spec_active = $urandom_range(0, 1); end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule